// File: doc/BRIEF.md
# Ethernet MAC interrupt moderation timer

This block limits how often a network MAC signals frame completion to the processor. It has two channels, one for receive completions and one for transmit completions. Each channel takes its delay from an 8-bit field of a 32-bit configuration word. The delay is counted in units of 800 ns. A zero field turns moderation off for that channel, and each completion then raises its status set strobe on the next clock. A non-zero field makes a completion start a timer. The status bit is set only when that timer runs out. Completions that arrive while the timer runs are merged into that one interrupt.

One prescaler serves both channels. It turns transmit-clock cycles into 800 ns ticks. Its divide ratio comes from three link-mode inputs: the serial-interface mode bit, the gigabit bit and the 100M speed bit. The outputs form an 8-bit vector of status set strobes. A moderated receive event always lands on bit 1 and a moderated transmit event always lands on bit 7. The surrounding status register ORs this vector into its stored bits.

Top module: `irqmod_top`

## Requirements
- R1: The receive delay count is taken from bits 7:0 of `mod_word` and the transmit delay count from bits 23:16. Every other bit of `mod_word` has no effect on either channel.
- R2: While reset is asserted and after it is released, `irq_set` stays all zero until a done pulse arrives, including done pulses applied during reset.
- R3: When a channel's count is zero, each done pulse sampled at a clock edge sets that channel's strobe during the cycle right after that edge. Back-to-back done pulses give back-to-back strobes.
- R4: When a channel's count C is non-zero, a done pulse sampled at edge E0 starts a timer. The strobe is set after edge E0+d, where (C-1)*P+1 <= d <= C*P and P is the tick period in clock cycles.
- R5: The tick period P is 100 cycles when the serial-interface bit or the gigabit bit is 1. Otherwise it is 20 cycles when the 100M bit is 1, and 2 cycles when all three bits are 0.
- R6: Done pulses that arrive while a channel's timer is running do not restart it or extend it. The run still ends in exactly one strobe.
- R7: Each expiry produces a strobe exactly one cycle wide. The channel then returns to idle, and the next done pulse starts a new run.
- R8: A change to a channel's count while its timer runs does not affect the current run. The new count applies from the next done pulse.
- R9: The receive and transmit channels time their events independently of each other, including when both start on the same edge with different counts.
- R10: Receive strobes appear only on `irq_set[1]` and transmit strobes only on `irq_set[7]`. All other bits of `irq_set` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; runs the prescaler and both channels |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_word | input | 32 | Moderation configuration word (receive count in bits 7:0, transmit count in bits 23:16) |
| link_tbi | input | 1 | Serial-interface mode bit; 1 selects the 100-cycle tick |
| link_gig | input | 1 | Gigabit mode bit; 1 selects the 100-cycle tick |
| link_100m | input | 1 | Speed bit; 1 selects 100M (20-cycle tick) when neither other mode bit is set |
| rx_done | input | 1 | One-cycle pulse per received frame |
| tx_done | input | 1 | One-cycle pulse per transmitted frame |
| irq_set | output | 8 | Status set strobes; bit 1 is receive, bit 7 is transmit |

## Verification
The bench measures the latency from each done pulse to its strobe under all four link modes. A prescaler that picks the wrong divide ratio lands outside the allowed window, and so does a channel that counts one tick too many or too few.

Reserved bits of the configuration word are filled with a pattern in every vector. A design that decodes a field from the wrong bits therefore shows a delay where a bypass was expected, or the reverse.

The bench also sends extra done pulses into a running timer and changes the count while a run is in progress. A design that restarts the timer would strobe late or twice, and one that reads the live count would strobe far outside the window.

Both channels are also started on the same edge with different counts. This exposes any crossing between channels or any sharing of timer state.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_RUN  = 1'b1
   } ch_state_e;

   typedef struct packed {
      logic serial_if;
      logic gigabit;
      logic fast_eth;
   } link_mode_t;

   typedef enum logic [1:0] {
      RATE_SLOW = 2'd0,
      RATE_MID  = 2'd1,
      RATE_FAST = 2'd2
   } rate_e;

   // Serial interface or gigabit wins over the 100M bit.
   function automatic rate_e decode_rate(input link_mode_t m);
      if (m.serial_if || m.gigabit) return RATE_FAST;
      if (m.fast_eth)               return RATE_MID;
      return RATE_SLOW;
   endfunction

endpackage

// File: rtl/irqmod_tick_gen.sv
module irqmod_tick_gen
   import irqmod_pkg::*;
#(
   parameter int unsigned DIV_FAST = 100,
   parameter int unsigned DIV_MID  = 20,
   parameter int unsigned DIV_SLOW = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  link_mode_t mode,
   output logic       tick
);

   localparam int unsigned DIV_HI  = (DIV_FAST > DIV_MID) ? DIV_FAST : DIV_MID;
   localparam int unsigned DIV_MAX = (DIV_HI > DIV_SLOW) ? DIV_HI : DIV_SLOW;
   localparam int unsigned CW      = $clog2(DIV_MAX);

   if (DIV_SLOW < 2 || DIV_MID < 2 || DIV_FAST < 2) begin : g_bad_div
      $error("irqmod_tick_gen: every divide ratio must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   always_comb begin
      unique case (decode_rate(mode))
         RATE_FAST: limit = CW'(DIV_FAST - 1);
         RATE_MID:  limit = CW'(DIV_MID - 1);
         default:   limit = CW'(DIV_SLOW - 1);
      endcase
   end

   // ">=" so a ratio shrink mid-period wraps at once instead of running to the top.
   assign tick = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   // R5: with every ratio at least 2, two ticks never come on adjacent cycles
   a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R5: the counter never runs past the largest ratio
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DIV_MAX - 1));

endmodule

// File: rtl/irqmod_field_pick.sv
module irqmod_field_pick #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned LSB    = 0
) (
   input  logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  count
);

   if (LSB + CNT_W > WORD_W) begin : g_bad_field
      $error("irqmod_field_pick: field runs past the word");
   end

   assign count = word[LSB +: CNT_W];

   logic unused_word;
   assign unused_word = ^word;

endmodule

// File: rtl/irqmod_channel.sv
module irqmod_channel
   import irqmod_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             done,
   input  logic [CNT_W-1:0] count,
   output logic             set_pulse
);

   if (CNT_W < 1) begin : g_bad_width
      $error("irqmod_channel: CNT_W must be at least 1");
   end

   ch_state_e        state_q;
   logic [CNT_W-1:0] rem_q;
   logic             set_q;
   logic             last_tick;

   assign last_tick = tick && (rem_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         rem_q   <= '0;
         set_q   <= 1'b0;
      end else begin
         set_q <= 1'b0;
         unique case (state_q)
            CH_IDLE: begin
               if (done) begin
                  if (count == '0) begin
                     set_q <= 1'b1;
                  end else begin
                     rem_q   <= count;
                     state_q <= CH_RUN;
                  end
               end
            end
            CH_RUN: begin
               // done is ignored here: merged into the pending expiry
               if (tick) begin
                  if (last_tick) begin
                     set_q   <= 1'b1;
                     state_q <= CH_IDLE;
                  end else begin
                     rem_q <= rem_q - 1'b1;
                  end
               end
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   assign set_pulse = set_q;

   // R3: zero count strobes on the very next cycle
   a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_IDLE && done && count == '0) |=> set_pulse);

   // R4: a non-zero count loads the timer with the count seen at the start
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_IDLE && done && count != '0) |=>
         (state_q == CH_RUN && rem_q == $past(count) && !set_pulse));

   // R4: each non-final tick takes exactly one unit off the timer
   a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RUN && tick && !last_tick) |=>
         (state_q == CH_RUN && rem_q == $past(rem_q) - 1'b1));

   // R6 / R8: without a tick, a running timer holds whatever done or count do
   a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RUN && !tick) |=>
         (state_q == CH_RUN && $stable(rem_q) && !set_pulse));

   // R7: expiry gives one strobe and goes back to idle
   a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RUN && last_tick) |=> (set_pulse && state_q == CH_IDLE));

   // R7: a strobe is only ever seen with the channel idle
   a_r7_idle_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |-> state_q == CH_IDLE);

endmodule

// File: rtl/irqmod_top.sv
module irqmod_top
   import irqmod_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned RX_LSB   = 0,
   parameter int unsigned TX_LSB   = 16,
   parameter int unsigned STAT_W   = 8,
   parameter int unsigned RX_BIT   = 1,
   parameter int unsigned TX_BIT   = 7,
   parameter int unsigned DIV_FAST = 100,
   parameter int unsigned DIV_MID  = 20,
   parameter int unsigned DIV_SLOW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] mod_word,
   input  logic              link_tbi,
   input  logic              link_gig,
   input  logic              link_100m,
   input  logic              rx_done,
   input  logic              tx_done,
   output logic [STAT_W-1:0] irq_set
);

   localparam int unsigned NUM_CH = 2;
   localparam logic [STAT_W-1:0] ALLOWED =
      (STAT_W'(1) << RX_BIT) | (STAT_W'(1) << TX_BIT);

   if (RX_BIT == TX_BIT || RX_BIT >= STAT_W || TX_BIT >= STAT_W) begin : g_bad_bits
      $error("irqmod_top: status bits must be distinct and inside the vector");
   end
   if (!(RX_LSB + CNT_W <= TX_LSB || TX_LSB + CNT_W <= RX_LSB)) begin : g_bad_fields
      $error("irqmod_top: receive and transmit fields overlap");
   end

   link_mode_t mode;
   logic       tick;
   logic [NUM_CH-1:0] done_v;
   logic [NUM_CH-1:0] set_v;

   assign mode   = '{serial_if: link_tbi, gigabit: link_gig, fast_eth: link_100m};
   assign done_v = {tx_done, rx_done};

   irqmod_tick_gen #(
      .DIV_FAST (DIV_FAST),
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .tick  (tick)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int unsigned FIELD_LSB = (ch == 0) ? RX_LSB : TX_LSB;
      logic [CNT_W-1:0] count;

      irqmod_field_pick #(
         .WORD_W (WORD_W),
         .CNT_W  (CNT_W),
         .LSB    (FIELD_LSB)
      ) u_pick (
         .word  (mod_word),
         .count (count)
      );

      irqmod_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .done      (done_v[ch]),
         .count     (count),
         .set_pulse (set_v[ch])
      );
   end

   always_comb begin
      irq_set         = '0;
      irq_set[RX_BIT] = set_v[0];
      irq_set[TX_BIT] = set_v[1];
   end

   // R10: only the two fixed status bits may ever be set
   a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_set & ~ALLOWED) == '0);

   // R2: no strobe in the cycle following reset release
   a_r2_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> irq_set == '0);

endmodule

// File: tb/irqmod_top_test.sv
`timescale 1ns/1ps
module irqmod_top_test;

   localparam int RXB = 1;
   localparam int TXB = 7;
   localparam logic [31:0] JUNK = 32'hC300_3C00;  // reserved bits only

   typedef struct packed {
      logic [1:0]  mode;   // 0: 10M, 1: 100M, 2: gigabit, 3: serial-if
      logic        ch;     // 0: receive, 1: transmit
      logic [7:0]  cnt;
      logic [15:0] lo;
      logic [15:0] hi;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b0, 8'd3,   16'd5,    16'd6},
      '{2'd1, 1'b1, 8'd2,   16'd21,   16'd40},
      '{2'd2, 1'b0, 8'd1,   16'd1,    16'd100},
      '{2'd3, 1'b1, 8'd2,   16'd101,  16'd200},
      '{2'd0, 1'b1, 8'd0,   16'd0,    16'd0},
      '{2'd1, 1'b0, 8'd0,   16'd0,    16'd0},
      '{2'd1, 1'b0, 8'd255, 16'd5081, 16'd5100},
      '{2'd2, 1'b1, 8'd3,   16'd201,  16'd300},
      '{2'd0, 1'b1, 8'd1,   16'd1,    16'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mod_word = '0;
   logic        link_tbi = 1'b0;
   logic        link_gig = 1'b0;
   logic        link_100m = 1'b0;
   logic        rx_done = 1'b0;
   logic        tx_done = 1'b0;
   logic [7:0]  irq_set;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   irqmod_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_word  (mod_word),
      .link_tbi  (link_tbi),
      .link_gig  (link_gig),
      .link_100m (link_100m),
      .rx_done   (rx_done),
      .tx_done   (tx_done),
      .irq_set   (irq_set)
   );

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         report();
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      link_tbi  = (m == 2'd3);
      link_gig  = (m == 2'd2);
      link_100m = (m == 2'd1);
   endtask

   function automatic logic [31:0] word_for(input logic ch, input logic [7:0] c);
      return ch ? (JUNK | {8'h00, c, 16'h0000}) : (JUNK | {24'h000000, c});
   endfunction

   // Pulse done on one channel, then watch; k=0 is the first negedge after the sampling edge.
   task automatic run_event(input logic ch, input int lo, input int hi, input string req);
      int first = -1;
      int hits  = 0;
      bit stray = 0;
      int own   = ch ? TXB : RXB;
      @(negedge clk);
      if (ch) tx_done = 1'b1; else rx_done = 1'b1;
      for (int k = 0; k <= hi + 6; k++) begin
         @(negedge clk);
         rx_done = 1'b0;
         tx_done = 1'b0;
         if (irq_set[own]) begin
            hits++;
            if (first < 0) first = k;
         end
         if ((irq_set & ~(8'(1) << own)) != 8'h00) stray = 1;
      end
      check(first >= lo && first <= hi, req, first, lo);
      check(hits == 1, "R7 single strobe", hits, 1);
      check(!stray, "R10 other bits quiet", stray, 0);
   endtask

   initial begin
      int first_rx;
      int first_tx;
      int hits_rx;
      int hits_tx;
      int hits;

      // R2: done pulses during reset leave the outputs quiet
      rx_done = 1'b1;
      tx_done = 1'b1;
      repeat (4) @(negedge clk);
      check(irq_set == 8'h00, "R2 quiet in reset", irq_set, 0);
      rx_done = 1'b0;
      tx_done = 1'b0;
      rst_n   = 1'b1;
      repeat (3) @(negedge clk);
      check(irq_set == 8'h00, "R2 quiet after reset", irq_set, 0);

      // Table walk: R1 (junk in reserved bits), R3, R4, R5, R10
      for (int i = 0; i < NV; i++) begin
         set_mode(VECS[i].mode);
         mod_word = word_for(VECS[i].ch, VECS[i].cnt);
         repeat (3) @(negedge clk);
         run_event(VECS[i].ch, int'(VECS[i].lo), int'(VECS[i].hi),
                   (VECS[i].cnt == 0) ? "R3 bypass latency / R1 field" :
                                        "R4 R5 latency window / R1 field");
      end

      // R3: back-to-back zero-count done pulses give back-to-back strobes
      set_mode(2'd1);
      mod_word = JUNK;
      @(negedge clk);
      rx_done = 1'b1;
      hits = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (k >= 2) rx_done = 1'b0;
         if (irq_set[RXB]) hits++;
      end
      check(hits == 3, "R3 back-to-back strobes", hits, 3);

      // R6: extra done pulses into a running timer (10M, count 5 -> window 9..10)
      set_mode(2'd0);
      mod_word = word_for(1'b0, 8'd5);
      repeat (3) @(negedge clk);
      rx_done = 1'b1;
      first_rx = -1;
      hits = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         rx_done = (k == 2 || k == 4 || k == 6);
         if (irq_set[RXB]) begin
            hits++;
            if (first_rx < 0) first_rx = k;
         end
      end
      check(first_rx >= 9 && first_rx <= 10, "R6 no restart latency", first_rx, 9);
      check(hits == 1, "R6 merged to one strobe", hits, 1);

      // R8: count change mid-run applies only to the next event
      mod_word = word_for(1'b0, 8'd4);
      repeat (3) @(negedge clk);
      rx_done = 1'b1;
      first_rx = -1;
      hits = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         rx_done = 1'b0;
         if (k == 1) mod_word = word_for(1'b0, 8'd50);
         if (irq_set[RXB]) begin
            hits++;
            if (first_rx < 0) first_rx = k;
         end
      end
      check(first_rx >= 7 && first_rx <= 8, "R8 current run keeps old count", first_rx, 7);
      check(hits == 1, "R8 single strobe", hits, 1);
      run_event(1'b0, 99, 100, "R8 next run uses new count");

      // R9: both channels start on the same edge with different counts
      mod_word = JUNK | {8'h00, 8'd6, 8'h00, 8'd3};
      repeat (3) @(negedge clk);
      rx_done = 1'b1;
      tx_done = 1'b1;
      first_rx = -1;
      first_tx = -1;
      hits_rx = 0;
      hits_tx = 0;
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         rx_done = 1'b0;
         tx_done = 1'b0;
         if (irq_set[RXB]) begin
            hits_rx++;
            if (first_rx < 0) first_rx = k;
         end
         if (irq_set[TXB]) begin
            hits_tx++;
            if (first_tx < 0) first_tx = k;
         end
      end
      check(first_rx >= 5 && first_rx <= 6, "R9 receive latency", first_rx, 5);
      check(first_tx >= 11 && first_tx <= 12, "R9 transmit latency", first_tx, 11);
      check(hits_rx == 1 && hits_tx == 1, "R9 one strobe each", hits_rx + hits_tx, 2);

      report();
   end

endmodule